// File: doc/BRIEF.md
# Reset Cause Status Controller

This block keeps a record of which event brought about the most recent reset. It also decides what happens to the low-voltage detector's configuration when a reset is taken. Seven one-cycle strobes report reset events: external pin, power-on, illegal instruction, watchdog, RAM parity error, illegal memory access and low-voltage detect. The block then updates a five-flag cause register, a detector enable bit and an eight-bit detector level register on the next clock edge.

Software reads the cause register by pulsing a read strobe. That read clears the flags, so the flags seen by the next read show only the resets taken since the previous one. The detector enable and level registers can be written by software in any cycle in which no reset strobe is active. When a reset is taken, those registers are either kept or reinitialised, depending on the source. The reinitialised level comes from a two-bit option setting.

Top module: `rcs_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cause_flags` is 0, `det_en` is 0 and `det_lvl` is 8'h00 until the first event or write.
- R2: If `ev_pin` or `ev_por` is high in a cycle, `cause_flags` is 0 after the next edge. This holds whatever other strobes or the read strobe are doing in that cycle.
- R3: `ev_ill`, `ev_wdt`, `ev_par` and `ev_iaw` set `cause_flags` bit 0, 1, 2 and 3 respectively. Every other flag keeps its value.
- R4: `ev_lvd` sets `cause_flags` bit 4 and keeps the other four flags.
- R5: If several strobes other than pin and power-on are high in one cycle, all of their flags are set on the same edge.
- R6: `rd_stb` clears the flags on the next edge; `cause_flags` shows the flags unchanged during the read cycle. Any flag whose strobe is high in the read cycle is set after that edge.
- R7: If any strobe other than `ev_lvd` is high, `det_en` becomes 0 on the next edge. If `ev_lvd` is the only strobe, `det_en` keeps its value.
- R8: If any strobe other than `ev_lvd` is high, `det_lvl` loads a value set by `opt_cfg` ({bit1,bit0}): 2'b10 gives 8'h00, 2'b11 gives 8'h81, 2'b01 gives 8'h01, and 2'b00 gives 8'h00.
- R9: If `ev_lvd` is the only strobe, `det_lvl` keeps its value.
- R10: If no strobe is high, `en_we` loads `en_wd` into `det_en` and `lvl_we` loads `lvl_wd` into `det_lvl` on the next edge. If any strobe is high, both writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low initialisation |
| ev_pin | input | 1 | External pin reset event strobe |
| ev_por | input | 1 | Power-on reset event strobe |
| ev_ill | input | 1 | Illegal instruction reset event strobe |
| ev_wdt | input | 1 | Watchdog reset event strobe |
| ev_par | input | 1 | RAM parity error reset event strobe |
| ev_iaw | input | 1 | Illegal memory access reset event strobe |
| ev_lvd | input | 1 | Low-voltage detect reset event strobe |
| opt_cfg | input | 2 | Option bits selecting the reinitialised level |
| rd_stb | input | 1 | Cause register read strobe (clear on next edge) |
| en_we | input | 1 | Detector enable write strobe |
| en_wd | input | 1 | Detector enable write value |
| lvl_we | input | 1 | Detector level write strobe |
| lvl_wd | input | 8 | Detector level write value |
| cause_flags | output | 5 | Cause flags: bit0 illegal instr, bit1 watchdog, bit2 parity, bit3 memory access, bit4 low-voltage |
| det_en | output | 1 | Detector enable register |
| det_lvl | output | 8 | Detector level register |

## Verification
The bench sweeps all 128 combinations of the seven strobes. Each combination is crossed with all four option codes, with the read strobe on and off, and with a preceding software write of enable 0 or 1. Flags left over from earlier combinations stay in place, so each sweep step tells apart a flag that was held from one that was cleared or newly set. Lone low-voltage strobes separate hold from reinitialise on registers that software has just loaded with nonzero values. The write attempted during every strobe cycle shows that a reset blocks a software write. The read cycles show whether clear or set wins when both happen on the same edge.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int CAUSE_W = 5;
    localparam int LVL_W   = 8;
    localparam int OPT_W   = 2;

    localparam int FL_ILL = 0;
    localparam int FL_WDT = 1;
    localparam int FL_PAR = 2;
    localparam int FL_IAW = 3;
    localparam int FL_LVD = 4;

    typedef struct packed {
        logic               clr_all;
        logic               reinit;
        logic               any;
        logic [CAUSE_W-1:0] set_vec;
    } rcs_evt_t;

    typedef struct packed {
        logic [CAUSE_W-1:0] flags;
    } rcs_cause_t;

    typedef struct packed {
        logic             en;
        logic [LVL_W-1:0] lvl;
    } rcs_det_t;

    function automatic logic [LVL_W-1:0] lvl_from_opt(input logic [OPT_W-1:0] opt);
        logic [LVL_W-1:0] v;
        case (opt)
            2'b11:   v = LVL_W'(8'h81);
            2'b01:   v = LVL_W'(8'h01);
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/rcs_prio.sv
module rcs_prio
    import rcs_pkg::*;
(
    input  logic     ev_pin,
    input  logic     ev_por,
    input  logic     ev_ill,
    input  logic     ev_wdt,
    input  logic     ev_par,
    input  logic     ev_iaw,
    input  logic     ev_lvd,
    output rcs_evt_t evt
);
    always_comb begin
        evt                 = '0;
        evt.clr_all         = ev_pin | ev_por;
        evt.set_vec[FL_ILL] = ev_ill;
        evt.set_vec[FL_WDT] = ev_wdt;
        evt.set_vec[FL_PAR] = ev_par;
        evt.set_vec[FL_IAW] = ev_iaw;
        evt.set_vec[FL_LVD] = ev_lvd;
        evt.reinit          = evt.clr_all | ev_ill | ev_wdt | ev_par | ev_iaw;
        evt.any             = evt.reinit | ev_lvd;
    end
endmodule

// File: rtl/rcs_cause.sv
module rcs_cause
    import rcs_pkg::*;
#(
    parameter int W = CAUSE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic         rd_stb,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] flags
);
    logic [W-1:0] flags_d, flags_q;

    for (genvar g = 0; g < W; g++) begin : g_flag
        always_comb begin
            if (clr_all)
                flags_d[g] = 1'b0;
            else if (set_vec[g])
                flags_d[g] = 1'b1;
            else if (rd_stb)
                flags_d[g] = 1'b0;
            else
                flags_d[g] = flags_q[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/rcs_det.sv
module rcs_det
    import rcs_pkg::*;
#(
    parameter int LW = LVL_W,
    parameter int OW = OPT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reinit,
    input  logic          any,
    input  logic [OW-1:0] opt_cfg,
    input  logic          en_we,
    input  logic          en_wd,
    input  logic          lvl_we,
    input  logic [LW-1:0] lvl_wd,
    output logic          det_en,
    output logic [LW-1:0] det_lvl
);
    rcs_det_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reinit) begin
            st_d.en  = 1'b0;
            st_d.lvl = lvl_from_opt(opt_cfg);
        end else if (!any) begin
            if (en_we)  st_d.en  = en_wd;
            if (lvl_we) st_d.lvl = lvl_wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign det_en  = st_q.en;
    assign det_lvl = st_q.lvl;
endmodule

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
    import rcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_pin,
    input  logic               ev_por,
    input  logic               ev_ill,
    input  logic               ev_wdt,
    input  logic               ev_par,
    input  logic               ev_iaw,
    input  logic               ev_lvd,
    input  logic [OPT_W-1:0]   opt_cfg,
    input  logic               rd_stb,
    input  logic               en_we,
    input  logic               en_wd,
    input  logic               lvl_we,
    input  logic [LVL_W-1:0]   lvl_wd,
    output logic [CAUSE_W-1:0] cause_flags,
    output logic               det_en,
    output logic [LVL_W-1:0]   det_lvl
);
    rcs_evt_t evt;

    rcs_prio u_prio (
        .ev_pin (ev_pin),
        .ev_por (ev_por),
        .ev_ill (ev_ill),
        .ev_wdt (ev_wdt),
        .ev_par (ev_par),
        .ev_iaw (ev_iaw),
        .ev_lvd (ev_lvd),
        .evt    (evt)
    );

    rcs_cause #(.W(CAUSE_W)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (evt.clr_all),
        .rd_stb  (rd_stb),
        .set_vec (evt.set_vec),
        .flags   (cause_flags)
    );

    rcs_det #(.LW(LVL_W), .OW(OPT_W)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .reinit  (evt.reinit),
        .any     (evt.any),
        .opt_cfg (opt_cfg),
        .en_we   (en_we),
        .en_wd   (en_wd),
        .lvl_we  (lvl_we),
        .lvl_wd  (lvl_wd),
        .det_en  (det_en),
        .det_lvl (det_lvl)
    );
endmodule

// File: rtl/rcs_chk.sv
module rcs_chk
    import rcs_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ev_pin,
    input logic               ev_por,
    input logic               ev_ill,
    input logic               ev_wdt,
    input logic               ev_par,
    input logic               ev_iaw,
    input logic               ev_lvd,
    input logic [OPT_W-1:0]   opt_cfg,
    input logic               rd_stb,
    input logic               en_we,
    input logic               en_wd,
    input logic               lvl_we,
    input logic [LVL_W-1:0]   lvl_wd,
    input logic [CAUSE_W-1:0] cause_flags,
    input logic               det_en,
    input logic [LVL_W-1:0]   det_lvl
);
    logic hard_ev, other_ev, lvd_only, no_ev;
    assign hard_ev  = ev_pin | ev_por;
    assign other_ev = hard_ev | ev_ill | ev_wdt | ev_par | ev_iaw;
    assign lvd_only = ev_lvd & ~other_ev;
    assign no_ev    = ~other_ev & ~ev_lvd;

    AST_HARD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hard_ev |=> cause_flags == '0); // R2

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hard_ev && !rd_stb) |=> ((cause_flags & $past(cause_flags)) == $past(cause_flags))); // R3

    AST_LVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_lvd && !hard_ev) |=> cause_flags[FL_LVD]); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && no_ev) |=> cause_flags == '0); // R6

    AST_EN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        other_ev |=> !det_en); // R7

    AST_LVL_HIGH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (other_ev && opt_cfg == 2'b11) |=> det_lvl == LVL_W'(8'h81)); // R8

    AST_DET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        lvd_only |=> ($stable(det_en) && $stable(det_lvl))); // R9

    AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (no_ev && lvl_we) |=> det_lvl == $past(lvl_wd)); // R10
endmodule

bind rcs_ctrl rcs_chk u_chk (.*);

// File: tb/sim_rcs_ctrl.sv
`timescale 1ns/1ps
module sim_rcs_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_pin = 0, ev_por = 0, ev_ill = 0, ev_wdt = 0, ev_par = 0, ev_iaw = 0, ev_lvd = 0;
    logic [1:0] opt_cfg = 2'b00;
    logic       rd_stb = 0, en_we = 0, en_wd = 0, lvl_we = 0;
    logic [7:0] lvl_wd = 8'h00;
    logic [4:0] cause_flags;
    logic       det_en;
    logic [7:0] det_lvl;

    int checks = 0;
    int errors = 0;
    logic [4:0] m_fl = '0;
    logic       m_en = 1'b0;
    logic [7:0] m_lvl = 8'h00;

    always #2.5 clk = ~clk;

    rcs_ctrl u0 (.*);

    function automatic logic [7:0] exp_lvl(input logic [1:0] o);
        if (o == 2'b11) return 8'h81;
        if (o == 2'b01) return 8'h01;
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // v bits: 0 pin, 1 por, 2 ill, 3 wdt, 4 par, 5 iaw, 6 lvd
    task automatic step(input logic [6:0] v, input logic [1:0] o, input logic rd,
                        input logic ewe, input logic ewd, input logic lwe, input logic [7:0] lwd);
        logic hard, reinit, any;
        string tf, td;
        {ev_lvd, ev_iaw, ev_par, ev_wdt, ev_ill, ev_por, ev_pin} = v;
        opt_cfg = o; rd_stb = rd; en_we = ewe; en_wd = ewd; lvl_we = lwe; lvl_wd = lwd;
        hard   = v[0] | v[1];
        reinit = |v[5:0];
        any    = |v;
        if (hard) begin
            m_fl = '0; tf = "R2";
        end else begin
            m_fl = (rd ? 5'b0 : m_fl) | v[6:2];
            if (rd) tf = "R6";
            else if ($countones(v[6:2]) > 1) tf = "R5";
            else if (v[6]) tf = "R4";
            else tf = "R3";
        end
        if (reinit) begin
            m_en = 1'b0; m_lvl = exp_lvl(o); td = "R7/R8";
        end else if (any) begin
            td = "R9";
        end else begin
            if (ewe) m_en = ewd;
            if (lwe) m_lvl = lwd;
            td = "R10";
        end
        @(negedge clk);
        chk(tf, {3'b0, cause_flags}, {3'b0, m_fl});
        chk(td, {7'b0, det_en}, {7'b0, m_en});
        chk(td, det_lvl, m_lvl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {3'b0, cause_flags}, 8'h00);
        chk("R1", {7'b0, det_en}, 8'h00);
        chk("R1", det_lvl, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {3'b0, cause_flags}, 8'h00);
        chk("R1", det_lvl, 8'h00);
        // reserved option code loads zero after a write of a nonzero level (R8)
        step(7'h00, 2'b00, 0, 1, 1, 1, 8'h5A);
        step(7'h04, 2'b00, 0, 0, 0, 0, 8'h00);
        for (int k = 0; k < 2048; k++) begin
            logic [6:0] v;
            logic [1:0] o;
            logic       rd, e;
            v  = 7'(k % 128);
            o  = 2'((k / 128) % 4);
            rd = k[9];
            e  = k[10] ^ k[0];
            // idle setup cycle: software loads enable and a level (R10)
            step(7'h00, o, 1'b0, 1'b1, e, 1'b1, 8'((k * 37 + 5) & 8'hFF));
            // event cycle with a competing write that must lose when any strobe is high
            step(v, o, rd, 1'b1, ~e, 1'b1, 8'((k * 91 + 3) & 8'hFF));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule